// File: doc/BRIEF.md
# Paged Register Slave for a Two-Wire Bus with Packet Error Code

This block is a slave on an SMBus/I2C two-wire bus. It gives a host byte-wide access to a bank of internal registers that is organised as pages. SCL and SDA are sampled with the system clock. START, repeated START and STOP are detected in that clock domain. The block answers on SDA through an open-drain enable: it only ever pulls the line low. Three transactions are served:

- **Write byte:** a register byte followed by one data byte.
- **Read byte:** a register byte, a repeated START, then one byte returned to the host.
- **Receive byte:** a read frame that returns the register at the internal pointer.

A write frame that ends after the register byte (send byte) only moves the pointer.

When the `pecEn` input is high, transfers are protected by a packet error code. This is a CRC-8 with polynomial x^8+x^2+x+1 and an initial value of zero. It is checked on the last byte of a write and appended to a read when the host acknowledges the data byte. The CRC runs over every byte from the START that left the bus idle, so the address byte after a repeated START is included.

One register address, 0xF0, holds the page number. All other accesses go to the register at the pointer's index inside the selected page.

Top module: `smb_reg_target`

## Requirements
- R1: The first byte after a START carries a 7-bit device address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). Only the address `DEV_ADDR` (default 7'h3A) is acknowledged. After a mismatch the slave leaves SDA released until the next START or STOP.
- R2: In a write frame the register byte and the data byte are each acknowledged, and the data byte is stored in the addressed register of the current page.
- R3: Valid register bytes are 0 to `PAGE_REGS-1` and the page-select address 0xF0. Any other register byte gets a NACK: the pointer keeps its value and no register changes.
- R4: A read byte frame (write-addressed register byte, repeated START, read-addressed frame) returns the contents of the named register.
- R5: A receive byte frame returns the register at the pointer. After every data byte sent to the host, the pointer steps by one. It wraps from `PAGE_REGS-1` to 0, and it stays put while it holds 0xF0.
- R6: A write frame that stops after an acknowledged register byte sets the pointer to that byte.
- R7: Writing a value below `NUM_PAGES` to 0xF0 selects that page, and reading 0xF0 returns the page. A larger value is ignored. After reset the page and the pointer are 0, and register i of page p holds p*32+i.
- R8: With `pecEn` high, a write frame carries a fourth byte. The slave acknowledges it only if it equals the CRC of the address byte, the register byte and the data byte. The data is stored only on a match.
- R9: With `pecEn` high, a host ACK on a returned data byte makes the slave send the CRC of all bytes of the transaction, including the read address byte after a repeated START.
- R10: `sdaOe` is 0 after reset and changes only while SCL is low. It is released after every acknowledge bit and after the last data bit.
- R11: A STOP or START in the middle of a byte abandons the frame, and the partial byte writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| sclIn | input | 1 | Bus clock line as seen on the pin |
| sdaIn | input | 1 | Bus data line as seen on the pin |
| pecEn | input | 1 | Packet error code enable |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
Each bus line passes through two synchroniser flops and an edge register. The slave therefore drives or releases SDA three to four system cycles after the SCL falling edge that starts a bit slot. The host model in the bench holds every SCL phase for ten cycles and samples SDA halfway through the high phase, which is well after that delay. A register write becomes visible to the next transaction, so stored data, pointer movement, page selection and the ignored cases (bad register, bad CRC, aborted byte) are each checked by a later bus read.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

  typedef enum logic [1:0] {K_ADDR, K_REG, K_DATA, K_PEC} rxKind_t;

  typedef struct packed {
    logic    crcClr;
    logic    rxBit;
    logic    sdaBit;
    logic    commit;
    rxKind_t kind;
    logic    loadData;
    logic    txShift;
    logic    ptrInc;
    logic    loadPec;
  } strobe_t;

  function automatic logic [7:0] crc8Step(input logic [7:0] crcIn, input logic [7:0] dat);
    logic [7:0] c;
    logic fb;
    c = crcIn;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ dat[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

endpackage

// File: rtl/smbt_ctrl.sv
module smbt_ctrl import smbt_pkg::*; (
  input  logic    clk,
  input  logic    rst,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    pecEn,
  input  logic    ackOk,
  input  logic    rwBit,
  input  logic    txNow,
  input  logic    txNext,
  output strobe_t st,
  output logic    sdaOe,
  output logic    sclLvl
);
  typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_RXEND, PH_ACKOUT, PH_TX, PH_ACKIN, PH_HOLD} phase_t;

  logic [1:0] sclQ, sdaQ;
  logic sclP, sdaP, sdaLvl;
  logic sclRise, sclFall, startEv, stopEv;
  phase_t phase;
  rxKind_t kindQ;
  logic [2:0] bitCnt;
  logic busy, ackQ, rwQ, hostAck, txPecQ;

  // two-flop synchronisers plus a previous-sample register for edges
  always_ff @(posedge clk) begin
    if (rst) begin
      sclQ <= 2'b11; sdaQ <= 2'b11; sclP <= 1'b1; sdaP <= 1'b1;
    end else begin
      sclQ <= {sclQ[0], sclIn};
      sdaQ <= {sdaQ[0], sdaIn};
      sclP <= sclQ[1];
      sdaP <= sdaQ[1];
    end
  end

  assign sclLvl  = sclQ[1];
  assign sdaLvl  = sdaQ[1];
  assign sclRise = sclLvl & ~sclP;
  assign sclFall = ~sclLvl & sclP;
  assign startEv = sclLvl & sclP & sdaP & ~sdaLvl;
  assign stopEv  = sclLvl & sclP & ~sdaP & sdaLvl;

  always_comb begin
    st = '0;
    st.kind     = kindQ;
    st.sdaBit   = sdaLvl;
    st.crcClr   = startEv & ~busy;
    st.rxBit    = (phase == PH_RX) & sclRise;
    st.commit   = (phase == PH_RXEND) & sclFall;
    st.loadData = st.commit & (kindQ == K_ADDR) & ackOk & rwBit;
    st.txShift  = (phase == PH_TX) & sclFall & (bitCnt != 3'd7);
    st.ptrInc   = (phase == PH_ACKIN) & sclRise & ~txPecQ;
    st.loadPec  = st.ptrInc & ~sdaLvl & pecEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE; kindQ <= K_ADDR; bitCnt <= '0; sdaOe <= 1'b0;
      busy <= 1'b0; ackQ <= 1'b0; rwQ <= 1'b0; hostAck <= 1'b0; txPecQ <= 1'b0;
    end else if (startEv) begin
      phase <= PH_RX; kindQ <= K_ADDR; bitCnt <= '0; sdaOe <= 1'b0; busy <= 1'b1;
    end else if (stopEv) begin
      phase <= PH_IDLE; sdaOe <= 1'b0; busy <= 1'b0;
    end else begin
      unique case (phase)
        PH_RX: if (sclRise) begin
          if (bitCnt == 3'd7) phase <= PH_RXEND;
          else bitCnt <= bitCnt + 3'd1;
        end
        PH_RXEND: if (sclFall) begin
          ackQ  <= ackOk;
          rwQ   <= rwBit;
          sdaOe <= ackOk;
          phase <= PH_ACKOUT;
        end
        PH_ACKOUT: if (sclFall) begin
          bitCnt <= '0;
          if (!ackQ) begin
            sdaOe <= 1'b0; phase <= PH_HOLD;
          end else begin
            unique case (kindQ)
              K_ADDR: if (rwQ) begin
                sdaOe <= ~txNow; phase <= PH_TX; txPecQ <= 1'b0;
              end else begin
                sdaOe <= 1'b0; phase <= PH_RX; kindQ <= K_REG;
              end
              K_REG: begin sdaOe <= 1'b0; phase <= PH_RX; kindQ <= K_DATA; end
              K_DATA: begin
                sdaOe <= 1'b0;
                if (pecEn) begin phase <= PH_RX; kindQ <= K_PEC; end
                else phase <= PH_HOLD;
              end
              default: begin sdaOe <= 1'b0; phase <= PH_HOLD; end
            endcase
          end
        end
        PH_TX: if (sclFall) begin
          if (bitCnt == 3'd7) begin
            sdaOe <= 1'b0; phase <= PH_ACKIN;
          end else begin
            sdaOe <= ~txNext; bitCnt <= bitCnt + 3'd1;
          end
        end
        PH_ACKIN: begin
          if (sclRise) hostAck <= ~sdaLvl;
          if (sclFall) begin
            bitCnt <= '0;
            if (hostAck && pecEn && !txPecQ) begin
              sdaOe <= ~txNow; phase <= PH_TX; txPecQ <= 1'b1;
            end else phase <= PH_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/smbt_dpath.sv
module smbt_dpath import smbt_pkg::*; #(
  parameter logic [6:0] DEV_ADDR  = 7'h3A,
  parameter int         PAGE_REGS = 16,
  parameter int         NUM_PAGES = 3,
  parameter logic [7:0] SEL_ADDR  = 8'hF0
) (
  input  logic       clk,
  input  logic       rst,
  input  strobe_t    st,
  input  logic       pecEn,
  output logic       ackOk,
  output logic       rwBit,
  output logic       txNow,
  output logic       txNext,
  output logic [7:0] ptrQ
);
  localparam int IW = $clog2(PAGE_REGS);
  localparam int PW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam logic [7:0] LAST_REG = 8'(PAGE_REGS - 1);
  localparam logic [7:0] PAGE_CNT = 8'(NUM_PAGES);

  logic [7:0] rxByte, txByte, crcQ, pendQ, readVal, wrData, crcA, crcB;
  logic [PW-1:0] pageQ;
  logic [7:0] mem [NUM_PAGES][PAGE_REGS];
  logic regHit, doWr;

  assign rwBit  = rxByte[0];
  assign txNow  = txByte[7];
  assign txNext = txByte[6];
  assign regHit = (rxByte <= LAST_REG) || (rxByte == SEL_ADDR);

  always_comb begin
    unique case (st.kind)
      K_ADDR:  ackOk = (rxByte[7:1] == DEV_ADDR);
      K_REG:   ackOk = regHit;
      K_DATA:  ackOk = 1'b1;
      default: ackOk = (rxByte == crcQ);
    endcase
  end

  always_comb begin
    if (ptrQ <= LAST_REG)      readVal = mem[pageQ][ptrQ[IW-1:0]];
    else if (ptrQ == SEL_ADDR) readVal = 8'(pageQ);
    else                       readVal = 8'hFF;
  end

  assign doWr   = st.commit && ((st.kind == K_DATA && !pecEn) || (st.kind == K_PEC && ackOk));
  assign wrData = (st.kind == K_DATA) ? rxByte : pendQ;
  assign crcA   = (st.commit && ackOk && st.kind != K_PEC) ? crc8Step(crcQ, rxByte) : crcQ;
  assign crcB   = st.loadData ? crc8Step(crcA, readVal) : crcA;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxByte <= '0; txByte <= '0; crcQ <= '0; pendQ <= '0; ptrQ <= '0; pageQ <= '0;
      for (int p = 0; p < NUM_PAGES; p++)
        for (int i = 0; i < PAGE_REGS; i++)
          mem[p][i] <= 8'(p * 32 + i);
    end else begin
      if (st.rxBit) rxByte <= {rxByte[6:0], st.sdaBit};
      crcQ <= st.crcClr ? 8'h00 : crcB;
      if (st.commit && st.kind == K_DATA) pendQ <= rxByte;
      if (st.loadData)     txByte <= readVal;
      else if (st.loadPec) txByte <= crcQ;
      else if (st.txShift) txByte <= {txByte[6:0], 1'b0};
      if (st.commit && st.kind == K_REG && regHit) ptrQ <= rxByte;
      else if (st.ptrInc && ptrQ <= LAST_REG) ptrQ <= (ptrQ == LAST_REG) ? 8'h00 : ptrQ + 8'd1;
      if (doWr) begin
        if (ptrQ <= LAST_REG) mem[pageQ][ptrQ[IW-1:0]] <= wrData;
        else if (ptrQ == SEL_ADDR && wrData < PAGE_CNT) pageQ <= wrData[PW-1:0];
      end
    end
  end

endmodule

// File: rtl/smb_reg_target.sv
module smb_reg_target import smbt_pkg::*; #(
  parameter logic [6:0] DEV_ADDR  = 7'h3A,
  parameter int         PAGE_REGS = 16,
  parameter int         NUM_PAGES = 3,
  parameter logic [7:0] SEL_ADDR  = 8'hF0
) (
  input  logic clk,
  input  logic rst,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic pecEn,
  output logic sdaOe
);
  strobe_t st;
  logic ackOk, rwBit, txNow, txNext, sclLvl;
  logic [7:0] ptrQ;

  smbt_ctrl uCtrl (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn), .pecEn(pecEn),
    .ackOk(ackOk), .rwBit(rwBit), .txNow(txNow), .txNext(txNext),
    .st(st), .sdaOe(sdaOe), .sclLvl(sclLvl)
  );

  smbt_dpath #(
    .DEV_ADDR(DEV_ADDR), .PAGE_REGS(PAGE_REGS), .NUM_PAGES(NUM_PAGES), .SEL_ADDR(SEL_ADDR)
  ) uDpath (
    .clk(clk), .rst(rst), .st(st), .pecEn(pecEn),
    .ackOk(ackOk), .rwBit(rwBit), .txNow(txNow), .txNext(txNext), .ptrQ(ptrQ)
  );

endmodule

// File: rtl/smbt_checker.sv
module smbt_checker import smbt_pkg::*; #(
  parameter int PAGE_REGS = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       sdaOe,
  input logic       sclLvl,
  input logic       ackOk,
  input strobe_t    st,
  input logic [7:0] ptrQ
);
  localparam logic [7:0] LASTR = 8'(PAGE_REGS - 1);

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdaOe) |-> !sclLvl); // R10

  AST_ADDR_MISS_NACK: assert property (@(posedge clk) disable iff (rst)
    (st.commit && st.kind == K_ADDR && !ackOk) |=> !sdaOe); // R1

  AST_BAD_REG_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st.commit && st.kind == K_REG && !ackOk) |=> $stable(ptrQ)); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (st.ptrInc && ptrQ < LASTR) |=> (ptrQ == $past(ptrQ) + 8'd1)); // R5

  AST_PEC_MISS_NACK: assert property (@(posedge clk) disable iff (rst)
    (st.commit && st.kind == K_PEC && !ackOk) |=> !sdaOe); // R8

endmodule

bind smb_reg_target smbt_checker #(.PAGE_REGS(PAGE_REGS)) uChk (
  .clk(clk), .rst(rst), .sdaOe(sdaOe), .sclLvl(sclLvl),
  .ackOk(ackOk), .st(st), .ptrQ(ptrQ)
);

// File: tb/tb_smb_reg_target.sv
`timescale 1ns/1ps
module tb_smb_reg_target;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h3A;
  localparam logic [7:0] AW = {DEV, 1'b0};
  localparam logic [7:0] AR = {DEV, 1'b1};

  typedef struct packed {
    logic       isRead;
    logic [7:0] r;
    logic [7:0] d;
    logic       expAck;
    logic [7:0] expD;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 8'h03, 8'h5C, 1'b1, 8'h00},
    '{1'b1, 8'h03, 8'h00, 1'b1, 8'h5C},
    '{1'b0, 8'h14, 8'h33, 1'b0, 8'h00},
    '{1'b1, 8'h03, 8'h00, 1'b1, 8'h5C},
    '{1'b0, 8'h0F, 8'hE1, 1'b1, 8'h00},
    '{1'b1, 8'h0F, 8'h00, 1'b1, 8'hE1},
    '{1'b1, 8'h07, 8'h00, 1'b1, 8'h07},
    '{1'b1, 8'h00, 8'h00, 1'b1, 8'h00}
  };

  logic clk = 1'b0, rst = 1'b1, sclH = 1'b1, hostOe = 1'b0, pecEn = 1'b0;
  logic sdaOe, sdaLine;
  int checks = 0, errors = 0;
  bit done = 0;

  assign sdaLine = !(hostOe || sdaOe);

  always #2.5 clk = ~clk;

  smb_reg_target dut (.clk(clk), .rst(rst), .sclIn(sclH), .sdaIn(sdaLine), .pecEn(pecEn), .sdaOe(sdaOe));

  function automatic logic [7:0] crcB(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    repeat (8) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    hostOe = 1'b0; waitQ(); sclH = 1'b1; waitQ(); hostOe = 1'b1; waitQ(); sclH = 1'b0; waitQ();
  endtask

  task automatic busStop();
    hostOe = 1'b1; waitQ(); sclH = 1'b1; waitQ(); hostOe = 1'b0; waitQ();
  endtask

  task automatic putBit(input logic b);
    hostOe = !b; waitQ(); sclH = 1'b1; waitQ(); waitQ(); sclH = 1'b0; waitQ();
  endtask

  task automatic putByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    hostOe = 1'b0; waitQ(); sclH = 1'b1; waitQ(); ack = !sdaLine; waitQ(); sclH = 1'b0; waitQ();
  endtask

  task automatic getByte(input logic ackIt, output logic [7:0] b);
    hostOe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); sclH = 1'b1; waitQ(); b[i] = sdaLine; waitQ(); sclH = 1'b0;
    end
    waitQ();
    hostOe = ackIt; waitQ(); sclH = 1'b1; waitQ(); waitQ(); sclH = 1'b0; waitQ(); hostOe = 1'b0;
  endtask

  // acks = {address, register, data, pec}
  task automatic doWrite(input logic [7:0] r, input logic [7:0] d, input logic usePec,
                         input logic corrupt, output logic [3:0] acks);
    logic [7:0] pec;
    pec = crcB(crcB(crcB(8'h00, AW), r), d) ^ (corrupt ? 8'h5A : 8'h00);
    acks = '0;
    busStart();
    putByte(AW, acks[3]); putByte(r, acks[2]); putByte(d, acks[1]);
    if (usePec) putByte(pec, acks[0]);
    busStop();
  endtask

  task automatic doRead(input logic [7:0] r, input logic usePec, output logic [7:0] d,
                        output logic [7:0] pec, output logic regAck);
    logic a;
    pec = 8'h00;
    busStart(); putByte(AW, a); putByte(r, regAck);
    busStart(); putByte(AR, a);
    getByte(usePec, d);
    if (usePec) getByte(1'b0, pec);
    busStop();
  endtask

  task automatic doRecv(input logic usePec, output logic [7:0] d, output logic [7:0] pec);
    logic a;
    pec = 8'h00;
    busStart(); putByte(AR, a);
    getByte(usePec, d);
    if (usePec) getByte(1'b0, pec);
    busStop();
  endtask

  task automatic doSend(input logic [7:0] r, output logic ack);
    logic a;
    busStart(); putByte(AW, a); putByte(r, ack); busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] acks;
    logic [7:0] d, pec;
    logic a;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // reset state
    chk("R10 sdaOe after reset", {7'd0, sdaOe}, 8'h00);
    doRecv(1'b0, d, pec); chk("R7 reset pointer/value", d, 8'h00);
    doRecv(1'b0, d, pec); chk("R5 pointer step", d, 8'h01);

    // vector table, PEC off
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VECS[i];
      if (v.isRead) begin
        doRead(v.r, 1'b0, d, pec, a);
        chk("R4 read byte value", d, v.expD);
      end else begin
        doWrite(v.r, v.d, 1'b0, 1'b0, acks);
        chk("R1 address ack", {7'd0, acks[3]}, 8'h01);
        chk("R2/R3 register ack", {7'd0, acks[2]}, {7'd0, v.expAck});
      end
    end

    // wrong device address
    busStart(); putByte({7'h3B, 1'b0}, a); busStop();
    chk("R1 foreign address nack", {7'd0, a}, 8'h00);

    // send byte then invalid register leaves pointer
    doSend(8'h05, a); chk("R6 send byte ack", {7'd0, a}, 8'h01);
    doWrite(8'h30, 8'h99, 1'b0, 1'b0, acks);
    chk("R3 invalid reg nack", {7'd0, acks[2]}, 8'h00);
    doRecv(1'b0, d, pec); chk("R3 pointer kept after nack", d, 8'h05);
    doRecv(1'b0, d, pec); chk("R5 pointer step", d, 8'h06);

    // wrap at last register
    doSend(8'h0F, a);
    doRecv(1'b0, d, pec); chk("R6 pointer from send byte", d, 8'hE1);
    doRecv(1'b0, d, pec); chk("R5 pointer wrap", d, 8'h00);

    // abort mid data byte
    busStart(); putByte(AW, a); putByte(8'h04, a);
    putBit(1'b1); putBit(1'b0); putBit(1'b1); putBit(1'b1);
    busStop();
    doRead(8'h04, 1'b0, d, pec, a); chk("R11 aborted byte not written", d, 8'h04);

    // pages
    doWrite(8'hF0, 8'h02, 1'b0, 1'b0, acks);
    doRead(8'h03, 1'b0, d, pec, a); chk("R7 page 2 reset value", d, 8'h43);
    doRead(8'hF0, 1'b0, d, pec, a); chk("R7 page readback", d, 8'h02);
    doWrite(8'hF0, 8'h03, 1'b0, 1'b0, acks);
    doRead(8'hF0, 1'b0, d, pec, a); chk("R7 out-of-range page ignored", d, 8'h02);
    doWrite(8'hF0, 8'h00, 1'b0, 1'b0, acks);
    doRead(8'h03, 1'b0, d, pec, a); chk("R7 back on page 0", d, 8'h5C);

    // PEC
    pecEn = 1'b1;
    doWrite(8'h09, 8'h77, 1'b1, 1'b0, acks);
    chk("R8 good pec ack", {7'd0, acks[0]}, 8'h01);
    doRead(8'h09, 1'b1, d, pec, a);
    chk("R8 pec write stored", d, 8'h77);
    chk("R9 read byte pec", pec, crcB(crcB(crcB(crcB(8'h00, AW), 8'h09), AR), 8'h77));
    doWrite(8'h09, 8'h11, 1'b1, 1'b1, acks);
    chk("R8 bad pec nack", {7'd0, acks[0]}, 8'h00);
    doRead(8'h09, 1'b1, d, pec, a);
    chk("R8 bad pec not stored", d, 8'h77);
    doRecv(1'b1, d, pec);
    chk("R9 receive byte data", d, 8'h0A);
    chk("R9 receive byte pec", pec, crcB(crcB(8'h00, AR), 8'h0A));
    chk("R10 sda released at end", {7'd0, sdaOe}, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule